// File: doc/BRIEF.md
# Transactional Read-Set Tracking Cache

This block is the tag and state side of a small direct-mapped data cache. It also remembers which lines the running transaction has read. The core drives a single request stream that carries four operations: begin a transaction, load, commit and abort. Another agent's write or invalidate arrives on a separate snoop port. Each line holds a valid bit, a tag and one read-set mark.

A load issued inside a transaction marks the line that it hits or allocates. Commit clears every mark in a single cycle, and so does any kind of abort. A snoop that hits a marked line while a transaction runs ends the transaction at once. So does a miss that would replace a marked line. Either event produces a one-cycle abort pulse and a registered cause code, which a software handler reads. Conflicts are resolved per line: any byte offset inside a marked line conflicts. Line data, refill from memory and the rest of the coherence protocol belong to neighbouring blocks.

The core request port uses valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in two cases: while `snp_valid` is high, because snoops take priority, and while a load response is held with `rsp_ready` low. The response port is valid/ready too. A response stays unchanged until it is taken. The snoop port and the transaction status pins are plain signals.

Top module: `tm_readset_cache`

## Requirements
- R1: After reset, no line is valid and `tx_active`, `abort_pulse`, `commit_pulse` and `rsp_valid` are all 0. `abort_cause` is 0 and `req_ready` is 1.
- R2: Every accepted load (`req_op`=1) returns exactly one response one cycle later. `rsp_hit` is 1 only if the indexed line is valid and its tag matches. A miss allocates the line, so a later load to any offset in that line hits. Address fields, with the default parameters: offset bits [3:0], index bits [6:4], tag bits [15:7].
- R3: The cache is direct-mapped. A miss whose index matches a valid line with a different tag replaces that line.
- R4: A snoop that hits a marked line while a transaction is active ends the transaction. It gives a one-cycle `abort_pulse`, and `abort_cause`=1 (conflict) from the next cycle on. A snoop address at any offset within the line counts.
- R5: A snoop that hits a valid line invalidates it. A snoop to an unmarked line, or one that misses, does not abort.
- R6: Commit (`req_op`=2) during a transaction gives a one-cycle `commit_pulse` and ends the transaction. It also clears every read-set mark at once, so a snoop to those lines in the next transaction does not abort.
- R7: A transactional load that misses and would replace a marked line aborts with `abort_cause`=2 (capacity). The new line is still allocated, unmarked, and the load reports a miss.
- R8: An abort request (`req_op`=3) during a transaction aborts with `abort_cause`=3. Like every abort, it clears all marks in the same cycle.
- R9: Loads outside a transaction set no mark. A snoop outside a transaction never raises `abort_pulse`.
- R10: A commit or abort request with no transaction active is ignored, and so is a begin (`req_op`=0) while a transaction is active.
- R11: `req_ready` is low while `snp_valid` is high, and while `rsp_valid` is high with `rsp_ready` low. A stalled response keeps `rsp_valid` and `rsp_hit` unchanged.
- R12: `abort_cause` keeps its value until the next accepted begin, which sets it back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request ready |
| req_op | input | 2 | 0 begin, 1 load, 2 commit, 3 abort |
| req_addr | input | ADDR_W | Byte address of a load |
| rsp_valid | output | 1 | Load response valid |
| rsp_ready | input | 1 | Load response taken |
| rsp_hit | output | 1 | Load hit the cache |
| snp_valid | input | 1 | Remote write or invalidate |
| snp_addr | input | ADDR_W | Snooped byte address |
| tx_active | output | 1 | Transaction running |
| abort_pulse | output | 1 | One-cycle abort notice |
| abort_cause | output | 2 | 0 none, 1 conflict, 2 capacity, 3 explicit |
| commit_pulse | output | 1 | One-cycle commit notice |

## Verification
The properties assume that the core holds `req_op` and `req_addr` steady while `req_valid` waits for `req_ready`. They also assume that the response consumer drives `rsp_ready` as a clean level, free of unknowns after reset. The bench changes its inputs only at falling edges. It keeps a request asserted across a stall, and it raises a snoop only while no core request is pending. As a result, every abort the bench expects comes from exactly one source in that cycle.

// File: rtl/tm_readset_pkg.sv
package tm_readset_pkg;
  typedef enum logic [1:0] {
    OP_BEGIN  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_COMMIT = 2'd2,
    OP_ABORT  = 2'd3
  } core_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_CAPACITY = 2'd2,
    CAUSE_EXPLICIT = 2'd3
  } abort_cause_e;
endpackage

// File: rtl/rs_line_array.sv
// Per-line valid, tag and read-set mark, with one lookup port for the core
// and one for snoops. The marks are flash-cleared as a group.
module rs_line_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             alloc_en,
  input  logic             mark_en,
  output logic             lk_hit,
  output logic             lk_vic_valid,
  output logic             lk_vic_rd,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  input  logic             inval_en,
  output logic             sn_hit,
  output logic             sn_rd,
  input  logic             flash_clr
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] rd_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic lk_sel;
    logic sn_sel;
    assign lk_sel = (lk_idx == IDX_W'(i));
    assign sn_sel = (sn_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        rd_q[i]    <= 1'b0;
        tag_q[i]   <= '0;
      end else begin
        if (inval_en && sn_sel) begin
          valid_q[i] <= 1'b0;
        end else if (alloc_en && lk_sel) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= lk_tag;
        end

        if (flash_clr || (inval_en && sn_sel)) begin
          rd_q[i] <= 1'b0;
        end else if (mark_en && lk_sel) begin
          rd_q[i] <= 1'b1;
        end else if (alloc_en && lk_sel) begin
          rd_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    lk_vic_valid = valid_q[lk_idx];
    lk_vic_rd    = rd_q[lk_idx];
    lk_hit       = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    sn_hit       = valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);
    sn_rd        = rd_q[sn_idx];
  end
endmodule

// File: rtl/rs_tx_ctrl.sv
// Transaction state, abort and commit pulses, and the held cause code.
module rs_tx_ctrl
  import tm_readset_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         begin_req,
  input  logic         commit_req,
  input  logic         abort_req,
  input  logic         conflict_evt,
  input  logic         capacity_evt,
  output logic         tx_active,
  output logic         abort_pulse,
  output logic         commit_pulse,
  output abort_cause_e abort_cause,
  output logic         flash_clr
);
  logic begin_ok;
  logic commit_ok;
  logic explicit_ok;
  logic abort_evt;

  assign begin_ok    = begin_req && !tx_active;
  assign commit_ok   = commit_req && tx_active;
  assign explicit_ok = abort_req && tx_active;
  assign abort_evt   = conflict_evt || capacity_evt || explicit_ok;
  assign flash_clr   = abort_evt || commit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_active    <= 1'b0;
      abort_pulse  <= 1'b0;
      commit_pulse <= 1'b0;
      abort_cause  <= CAUSE_NONE;
    end else begin
      abort_pulse  <= abort_evt;
      commit_pulse <= commit_ok;
      if (abort_evt || commit_ok) begin
        tx_active <= 1'b0;
      end else if (begin_ok) begin
        tx_active <= 1'b1;
      end

      if (conflict_evt) begin
        abort_cause <= CAUSE_CONFLICT;
      end else if (capacity_evt) begin
        abort_cause <= CAUSE_CAPACITY;
      end else if (explicit_ok) begin
        abort_cause <= CAUSE_EXPLICIT;
      end else if (begin_ok) begin
        abort_cause <= CAUSE_NONE;
      end
    end
  end
endmodule

// File: rtl/tm_readset_cache.sv
module tm_readset_cache
  import tm_readset_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              tx_active,
  output logic              abort_pulse,
  output logic [1:0]        abort_cause,
  output logic              commit_pulse
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int IDX_LO = OFF_W;
  localparam int TAG_LO = OFF_W + IDX_W;

  core_op_e     op;
  logic         accept;
  logic         ld_acc;
  logic         lk_hit, lk_vic_valid, lk_vic_rd;
  logic         sn_hit, sn_rd;
  logic         capacity_evt, conflict_evt;
  logic         mark_en, alloc_en, inval_en, flash_clr;
  abort_cause_e cause_q;
  logic         unused_offset_bits;

  assign unused_offset_bits = ^{req_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  assign op        = core_op_e'(req_op);
  assign req_ready = !snp_valid && !(rsp_valid && !rsp_ready);
  assign accept    = req_valid && req_ready;
  assign ld_acc    = accept && (op == OP_LOAD);

  assign alloc_en     = ld_acc && !lk_hit;
  assign capacity_evt = alloc_en && tx_active && lk_vic_valid && lk_vic_rd;
  assign mark_en      = ld_acc && tx_active && !capacity_evt;
  assign inval_en     = snp_valid && sn_hit;
  assign conflict_evt = inval_en && sn_rd && tx_active;

  rs_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_idx       (req_addr[IDX_LO +: IDX_W]),
    .lk_tag       (req_addr[TAG_LO +: TAG_W]),
    .alloc_en     (alloc_en),
    .mark_en      (mark_en),
    .lk_hit       (lk_hit),
    .lk_vic_valid (lk_vic_valid),
    .lk_vic_rd    (lk_vic_rd),
    .sn_idx       (snp_addr[IDX_LO +: IDX_W]),
    .sn_tag       (snp_addr[TAG_LO +: TAG_W]),
    .inval_en     (inval_en),
    .sn_hit       (sn_hit),
    .sn_rd        (sn_rd),
    .flash_clr    (flash_clr)
  );

  rs_tx_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .begin_req    (accept && (op == OP_BEGIN)),
    .commit_req   (accept && (op == OP_COMMIT)),
    .abort_req    (accept && (op == OP_ABORT)),
    .conflict_evt (conflict_evt),
    .capacity_evt (capacity_evt),
    .tx_active    (tx_active),
    .abort_pulse  (abort_pulse),
    .commit_pulse (commit_pulse),
    .abort_cause  (cause_q),
    .flash_clr    (flash_clr)
  );
  assign abort_cause = cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else if (ld_acc) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lk_hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tm_readset_cache_chk.sv
module tm_readset_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_hit,
  input logic       snp_valid,
  input logic       tx_active,
  input logic       abort_pulse,
  input logic [1:0] abort_cause,
  input logic       commit_pulse
);
  p_abort_ends_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !tx_active);

  p_abort_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (abort_cause != 2'd0));

  p_single_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_pulse && commit_pulse));

  p_idle_snoop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !tx_active) |=> !abort_pulse);

  p_start_needs_begin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(req_valid && req_ready && req_op == 2'd0));

  p_idle_end_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1] && !tx_active) |=> (!commit_pulse && !abort_pulse));

  p_snoop_stalls_core_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)));
endmodule

bind tm_readset_cache tm_readset_cache_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_hit      (rsp_hit),
  .snp_valid    (snp_valid),
  .tx_active    (tx_active),
  .abort_pulse  (abort_pulse),
  .abort_cause  (abort_cause),
  .commit_pulse (commit_pulse)
);

// File: tb/tb_tm_readset_cache.sv
module tb_tm_readset_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  typedef struct packed {
    logic        snoop;
    logic [1:0]  op;
    logic [15:0] addr;
    logic        hit;
    logic        act;
    logic        abt;
    logic [1:0]  cause;
    logic        cmt;
    logic [3:0]  rq;
  } vec_t;

  // fields: snoop, op(0 begin 1 load 2 commit 3 abort), addr, hit, active, abort, cause, commit, req
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 16'h0090, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd2 },  // R2 miss allocates
    '{1'b0, 2'd1, 16'h0094, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd2 },  // R2 other offset hits
    '{1'b1, 2'd0, 16'h0098, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd9 },  // R9 idle snoop quiet
    '{1'b0, 2'd1, 16'h0090, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd5 },  // R5 invalidated
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd4 },  // begin
    '{1'b0, 2'd1, 16'h00A0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd2 },  // mark idx2
    '{1'b1, 2'd0, 16'h00B0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd5 },  // R5 snoop miss
    '{1'b1, 2'd0, 16'h009C, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd5 },  // R5 unmarked hit
    '{1'b0, 2'd1, 16'h0090, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd5 },  // R5 miss after inval
    '{1'b1, 2'd0, 16'h00AC, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd4 },  // R4 conflict
    '{1'b0, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd10},  // R10 idle commit
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd12},  // R12 begin clears cause
    '{1'b1, 2'd0, 16'h0094, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd4 },  // R4 marks cleared by abort
    '{1'b0, 2'd1, 16'h00A0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd5 },  // R5 miss after conflict inval
    '{1'b0, 2'd1, 16'h0110, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd3 },  // R3 alloc idx1 tag2
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd10},  // R10 nested begin
    '{1'b0, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd6 },  // R6 commit
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd6 },  // begin
    '{1'b1, 2'd0, 16'h00A0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd6 },  // R6 cleared by commit
    '{1'b0, 2'd1, 16'h0110, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 4'd3 },  // R3 hit, marks idx1
    '{1'b0, 2'd1, 16'h0090, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 4'd7 },  // R7 capacity abort
    '{1'b0, 2'd1, 16'h0090, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 4'd7 },  // R7 new line allocated
    '{1'b0, 2'd1, 16'h0110, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 4'd3 },  // R3 replaced
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd12},  // R12
    '{1'b0, 2'd1, 16'h00B0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd2 },  // mark idx3
    '{1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 4'd8 },  // R8 explicit abort
    '{1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 4'd10},  // R10 idle abort
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd4 },  // begin
    '{1'b1, 2'd0, 16'h00B4, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd8 },  // R8 marks flash-cleared
    '{1'b0, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd6 }   // R6 commit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic        snp_valid = 1'b0;
  logic [15:0] snp_addr = '0;
  logic        tx_active;
  logic        abort_pulse;
  logic [1:0]  abort_cause;
  logic        commit_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tm_readset_cache dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .tx_active(tx_active), .abort_pulse(abort_pulse), .abort_cause(abort_cause),
    .commit_pulse(commit_pulse)
  );

  task automatic check(input int rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, "tx_active", int'(tx_active), 0);
    check(1, "abort_pulse", int'(abort_pulse), 0);
    check(1, "commit_pulse", int'(commit_pulse), 0);
    check(1, "abort_cause", int'(abort_cause), 0);
    check(1, "rsp_valid", int'(rsp_valid), 0);
    check(1, "req_ready", int'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].snoop) begin
        snp_valid = 1'b1;
        snp_addr  = VEC[i].addr;
      end else begin
        req_valid = 1'b1;
        req_op    = VEC[i].op;
        req_addr  = VEC[i].addr;
      end
      @(negedge clk);
      snp_valid = 1'b0;
      req_valid = 1'b0;
      check(int'(VEC[i].rq), $sformatf("vec%0d tx_active", i), int'(tx_active), int'(VEC[i].act));
      check(int'(VEC[i].rq), $sformatf("vec%0d abort_pulse", i), int'(abort_pulse), int'(VEC[i].abt));
      check(int'(VEC[i].rq), $sformatf("vec%0d abort_cause", i), int'(abort_cause), int'(VEC[i].cause));
      check(int'(VEC[i].rq), $sformatf("vec%0d commit_pulse", i), int'(commit_pulse), int'(VEC[i].cmt));
      if (!VEC[i].snoop && VEC[i].op == 2'd1) begin
        check(int'(VEC[i].rq), $sformatf("vec%0d rsp_valid", i), int'(rsp_valid), 1);
        check(int'(VEC[i].rq), $sformatf("vec%0d rsp_hit", i), int'(rsp_hit), int'(VEC[i].hit));
      end else begin
        check(int'(VEC[i].rq), $sformatf("vec%0d rsp_valid", i), int'(rsp_valid), 0);
      end
    end

    // R11 response stall holds the response and blocks the next request
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0110;
    @(negedge clk);
    check(11, "stall rsp_valid", int'(rsp_valid), 1);
    check(11, "stall rsp_hit", int'(rsp_hit), 1);
    check(11, "stall req_ready", int'(req_ready), 0);
    req_addr = 16'h00C0;
    @(negedge clk);
    check(11, "held rsp_valid", int'(rsp_valid), 1);
    check(11, "held rsp_hit", int'(rsp_hit), 1);
    check(11, "held req_ready", int'(req_ready), 0);
    rsp_ready = 1'b1;
    #1;
    check(11, "release req_ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(11, "next rsp_valid", int'(rsp_valid), 1);
    check(11, "next rsp_hit (miss)", int'(rsp_hit), 0);
    // R11 snoop stalls the core port
    snp_valid = 1'b1; snp_addr = 16'h0F00;
    #1;
    check(11, "snoop req_ready", int'(req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    check(11, "after snoop req_ready", int'(req_ready), 1);

    // R1 reset returns to the idle state
    req_valid = 1'b1; req_op = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(1, "reset tx_active", int'(tx_active), 0);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0090;
    @(negedge clk);
    req_valid = 1'b0;
    check(1, "reset lines invalid", int'(rsp_hit), 0);
    check(1, "reset rsp_valid", int'(rsp_valid), 1);
    @(negedge clk);
    finish_run();
  end
endmodule